// File: doc/BRIEF.md
# Three-Port Bus Exchanger with Universal Storage

This block joins three 16-bit bidirectional ports, A, B and C. A word that arrives on any port can be passed to either or both of the other two ports. Each port has its own input storage element. The element's mode is set by two controls, a hold-open control and a clock-gate control, and by a per-port capture strobe. It can run transparent, latched, edge-clocked or edge-clocked with a clock gate. Each port drives the output of one of the other two ports' storage elements, so live and stored words can be mixed freely across the three ports.

Each tri-state pin group is split into an input bus, an output bus and a drive-enable flag. The external pad logic combines them into a real bidirectional pin.

All state runs on the system clock `clk`. Each port strobe (`*_pclk`) is sampled on `clk`. A rising strobe edge is a low sample followed by a high sample on consecutive `clk` edges. The strobe must therefore hold each level for at least one `clk` cycle.

Top module: `tri_port_exchanger`

## Requirements
- R1: After a synchronous reset, every storage element holds zero and every `*_drive` flag is 0.
- R2: While a port's hold-open control (`*_le`) is 1, its input word reaches the other ports' outputs in the same cycle, with no clock edge needed.
- R3: On the cycle when `*_le` goes from 1 to 0, the element keeps the word that was present in the last cycle that `*_le` was 1, and later input changes are not seen.
- R4: With `*_le` at 0 and the clock gate (`*_ce_n`) at 0, a rising strobe edge captures the input word. The new word appears on the `clk` edge that samples the strobe high.
- R5: With `*_le` at 0 and the strobe held at a steady level, the stored word does not change, whatever the input does.
- R6: With `*_le` at 0 and `*_ce_n` at 1, rising strobe edges are ignored and the stored word is kept.
- R7: The one-bit select works as follows:
  - Port A drives B's element output when `a_sel`=0 and C's when it is 1.
  - Port B drives A's element output when `b_sel`=0 and C's when it is 1.
  - Port C drives A's element output when `c_sel`=0 and B's when it is 1.
- R8: One source port can feed both other ports in the same cycle.
- R9: `*_drive` equals the inverse of `*_oe_n`, registered on `clk` one cycle later (1 means the port drives, 0 means high impedance). Output data is valid regardless of the drive flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_din | input | 16 | Port A input word |
| a_dout | output | 16 | Port A output word |
| a_drive | output | 1 | Port A drive enable (1 = drive) |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_sel | input | 1 | Port A source select |
| a_le | input | 1 | Port A hold-open (transparent) control |
| a_pclk | input | 1 | Port A capture strobe |
| a_ce_n | input | 1 | Port A clock gate, active low |
| b_din | input | 16 | Port B input word |
| b_dout | output | 16 | Port B output word |
| b_drive | output | 1 | Port B drive enable |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_sel | input | 1 | Port B source select |
| b_le | input | 1 | Port B hold-open control |
| b_pclk | input | 1 | Port B capture strobe |
| b_ce_n | input | 1 | Port B clock gate, active low |
| c_din | input | 16 | Port C input word |
| c_dout | output | 16 | Port C output word |
| c_drive | output | 1 | Port C drive enable |
| c_oe_n | input | 1 | Port C output enable, active low |
| c_sel | input | 1 | Port C source select |
| c_le | input | 1 | Port C hold-open control |
| c_pclk | input | 1 | Port C capture strobe |
| c_ce_n | input | 1 | Port C clock gate, active low |

## Verification
Two functions can meet in one cycle: a port's element can be transparent, or it can be capturing on a strobe edge, while another port reads it through its select. The bench provokes this by randomising `*_le`, `*_ce_n`, the strobes and the selects every cycle. It then compares each output just before the clock edge against a model that applies bypass first and the stored word otherwise. Directed steps add a `*_le` falling edge with the input changing at the same moment. They also add a single source fanned out to both other ports in the same cycle as a capture edge.

// File: rtl/ube_pkg.sv
package ube_pkg;
  localparam int NPORT = 3;

  // Source port chosen by port p: the lower-numbered other port on sel=0,
  // the higher-numbered other port on sel=1.
  function automatic int src_of(input int p, input logic sel);
    int lo;
    int hi;
    lo = (p == 0) ? 1 : 0;
    hi = (p == NPORT - 1) ? NPORT - 2 : NPORT - 1;
    return sel ? hi : lo;
  endfunction
endpackage

// File: rtl/ube_cell.sv
module ube_cell #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         pclk,
  input  logic         ce_n,
  output logic [W-1:0] val
);
  logic [W-1:0] q;
  logic         pclk_d;
  logic         rise;

  assign rise = pclk & ~pclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      pclk_d <= 1'b1;
    end else begin
      pclk_d <= pclk;
      if (le)
        q <= din;
      else if (!ce_n && rise)
        q <= din;
    end
  end

  // bypass around the register while open
  assign val = le ? din : q;

  // R1: cleared by reset
  p_clear_r1: assert property (@(posedge clk) rst |=> (q == '0));

  // R3: while open the register follows the input, so it holds the last open value
  p_follow_r3: assert property (@(posedge clk) disable iff (rst)
    le |=> (q == $past(din)));

  // R4: gated rising strobe captures
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (!le && !ce_n && pclk && !pclk_d) |=> (q == $past(din)));

  // R5: steady strobe keeps the word
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!le && (pclk == pclk_d)) |=> $stable(q));

  // R6: closed clock gate ignores edges
  p_ignore_r6: assert property (@(posedge clk) disable iff (rst)
    (!le && ce_n) |=> $stable(q));
endmodule

// File: rtl/ube_route.sv
module ube_route
  import ube_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPORT-1:0][W-1:0] v,
  input  logic [NPORT-1:0]      sel,
  input  logic [NPORT-1:0]      oe_n,
  output logic [NPORT-1:0][W-1:0] dout,
  output logic [NPORT-1:0]      drive
);
  for (genvar p = 0; p < NPORT; p++) begin : g_mux
    assign dout[p] = v[src_of(p, sel[p])];
  end

  always_ff @(posedge clk) begin
    if (rst) drive <= '0;
    else     drive <= ~oe_n;
  end

  // R1: no port drives after reset
  p_quiet_r1: assert property (@(posedge clk) rst |=> (drive == '0));

  // R9: drive flag is the registered inverse of the enable
  p_oe_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drive == ~$past(oe_n)));

  // R8: a source picked by both other ports reaches both
  p_fan_r8: assert property (@(posedge clk) disable iff (rst)
    (!sel[1] && !sel[2]) |-> (dout[1] == dout[2]));
endmodule

// File: rtl/tri_port_exchanger.sv
module tri_port_exchanger
  import ube_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         a_drive,
  input  logic         a_oe_n,
  input  logic         a_sel,
  input  logic         a_le,
  input  logic         a_pclk,
  input  logic         a_ce_n,
  input  logic [W-1:0] b_din,
  output logic [W-1:0] b_dout,
  output logic         b_drive,
  input  logic         b_oe_n,
  input  logic         b_sel,
  input  logic         b_le,
  input  logic         b_pclk,
  input  logic         b_ce_n,
  input  logic [W-1:0] c_din,
  output logic [W-1:0] c_dout,
  output logic         c_drive,
  input  logic         c_oe_n,
  input  logic         c_sel,
  input  logic         c_le,
  input  logic         c_pclk,
  input  logic         c_ce_n
);
  logic [NPORT-1:0][W-1:0] din_v;
  logic [NPORT-1:0][W-1:0] val_v;
  logic [NPORT-1:0][W-1:0] dout_v;
  logic [NPORT-1:0]        le_v, pclk_v, ce_n_v, sel_v, oe_n_v, drive_v;

  assign din_v  = {c_din, b_din, a_din};
  assign le_v   = {c_le, b_le, a_le};
  assign pclk_v = {c_pclk, b_pclk, a_pclk};
  assign ce_n_v = {c_ce_n, b_ce_n, a_ce_n};
  assign sel_v  = {c_sel, b_sel, a_sel};
  assign oe_n_v = {c_oe_n, b_oe_n, a_oe_n};

  for (genvar p = 0; p < NPORT; p++) begin : g_cell
    ube_cell #(.W(W)) i_cell (
      .clk  (clk),
      .rst  (rst),
      .din  (din_v[p]),
      .le   (le_v[p]),
      .pclk (pclk_v[p]),
      .ce_n (ce_n_v[p]),
      .val  (val_v[p])
    );
  end

  ube_route #(.W(W)) i_route (
    .clk   (clk),
    .rst   (rst),
    .v     (val_v),
    .sel   (sel_v),
    .oe_n  (oe_n_v),
    .dout  (dout_v),
    .drive (drive_v)
  );

  assign a_dout  = dout_v[0];
  assign b_dout  = dout_v[1];
  assign c_dout  = dout_v[2];
  assign a_drive = drive_v[0];
  assign b_drive = drive_v[1];
  assign c_drive = drive_v[2];
endmodule

// File: tb/test_tri_port_exchanger.sv
`timescale 1ns/1ps
module test_tri_port_exchanger;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] din [3];
  logic le [3], pclk [3], ce_n [3], sel [3], oe_n [3];
  logic [W-1:0] dout [3];
  logic drive [3];

  logic [W-1:0] mq [3];
  logic mprev [3];
  logic mdrv [3];

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tri_port_exchanger #(.W(W)) i_tri_port_exchanger (
    .clk(clk), .rst(rst),
    .a_din(din[0]), .a_dout(dout[0]), .a_drive(drive[0]), .a_oe_n(oe_n[0]),
    .a_sel(sel[0]), .a_le(le[0]), .a_pclk(pclk[0]), .a_ce_n(ce_n[0]),
    .b_din(din[1]), .b_dout(dout[1]), .b_drive(drive[1]), .b_oe_n(oe_n[1]),
    .b_sel(sel[1]), .b_le(le[1]), .b_pclk(pclk[1]), .b_ce_n(ce_n[1]),
    .c_din(din[2]), .c_dout(dout[2]), .c_drive(drive[2]), .c_oe_n(oe_n[2]),
    .c_sel(sel[2]), .c_le(le[2]), .c_pclk(pclk[2]), .c_ce_n(ce_n[2])
  );

  function automatic int src(input int p, input logic s);
    if (p == 0) return s ? 2 : 1;
    if (p == 1) return s ? 2 : 0;
    return s ? 1 : 0;
  endfunction

  function automatic logic [W-1:0] exp_out(input int p);
    int s;
    s = src(p, sel[p]);
    return le[s] ? din[s] : mq[s];
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    for (int p = 0; p < 3; p++) begin
      if (rst) begin
        mq[p] = '0; mprev[p] = 1'b1; mdrv[p] = 1'b0;
      end else begin
        if (le[p]) mq[p] = din[p];
        else if (!ce_n[p] && pclk[p] && !mprev[p]) mq[p] = din[p];
        mprev[p] = pclk[p];
        mdrv[p] = ~oe_n[p];
      end
    end
    @(negedge clk);
  endtask

  initial begin
    for (int p = 0; p < 3; p++) begin
      din[p] = '0; le[p] = 0; pclk[p] = 0; ce_n[p] = 1; sel[p] = 0; oe_n[p] = 1;
      mq[p] = '0; mprev[p] = 1; mdrv[p] = 0;
    end
    void'($urandom(32'd20240611));
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    for (int p = 0; p < 3; p++) begin
      chk("R1 dout", dout[p], '0);
      chk("R1 drive", {15'd0, drive[p]}, '0);
    end
    // R2 transparent path, same cycle
    le[0] = 1; din[0] = 16'h1234; sel[1] = 0;
    #1 chk("R2 live", dout[1], 16'h1234);
    tick();
    // R3 close and change input
    le[0] = 0; din[0] = 16'hFFFF;
    #1 chk("R3 closed", dout[1], 16'h1234);
    tick();
    chk("R3 kept", dout[1], 16'h1234);
    // R4/R5 strobe capture on B
    din[1] = 16'h0BEE; ce_n[1] = 0; pclk[1] = 1; sel[0] = 0;
    #1 chk("R5 before edge", dout[0], 16'h0000);
    tick();
    chk("R4 captured", dout[0], 16'h0BEE);
    din[1] = 16'h7777;
    tick();
    chk("R5 steady high", dout[0], 16'h0BEE);
    pclk[1] = 0; tick();
    chk("R5 steady low", dout[0], 16'h0BEE);
    // R6 gated edge ignored on C
    ce_n[2] = 1; din[2] = 16'h5A5A; pclk[2] = 0; tick();
    pclk[2] = 1; tick();
    sel[0] = 1;
    #1 chk("R6 ignored", dout[0], 16'h0000);
    // R8 one source to both ports, with a capture on A at the same time
    le[2] = 1; din[2] = 16'hC0DE; sel[0] = 1; sel[1] = 1;
    ce_n[0] = 0; din[0] = 16'h4321; pclk[0] = 1;
    #1 chk("R8 to A", dout[0], 16'hC0DE);
    chk("R8 to B", dout[1], 16'hC0DE);
    tick();
    sel[2] = 0;
    chk("R8 A captured", dout[2], 16'h4321);
    // R9 registered drive flag
    oe_n[1] = 0;
    #1 chk("R9 before", {15'd0, drive[1]}, 16'd0);
    tick();
    chk("R9 after", {15'd0, drive[1]}, 16'd1);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < 3; p++) begin
        din[p]  = W'($urandom);
        le[p]   = ($urandom % 4) == 0;
        pclk[p] = $urandom % 2;
        ce_n[p] = $urandom % 2;
        sel[p]  = $urandom % 2;
        oe_n[p] = $urandom % 2;
      end
      #1;
      for (int p = 0; p < 3; p++) begin
        chk("R7 route", dout[p], exp_out(p));
        chk("R9 drive", {15'd0, drive[p]}, {15'd0, mdrv[p]});
      end
      tick();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule